// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Flags

This block sits between a UART deserializer and the register read port. Each time the deserializer finishes a frame, it presents three things for one cycle: the data bits, the parity bit it received and the stop bit it sampled. The block checks the parity if parity checking is turned on. It then writes the data into a small FIFO along with that frame's own error flags: parity error, stop-bit value and data overrun.

The read side always shows the oldest unread character and that character's flags. A read strobe consumes the character. When the FIFO is empty, the data port keeps showing the last character that was consumed, and every flag reads zero. Clearing the receive-enable input empties the FIFO at once, and any frame completing while the receiver is disabled is thrown away.

Software can drain the buffer by reading until the receive-complete output falls. If frames arrive while every slot is full, the newest frame is lost. The loss is marked on the newest character still stored, so it shows up when software reaches that character.

Top module: `uart_rx_buf`

## Requirements
- R1: The parity-error output is 0 while `par_en` is 0. A frame that completes while `par_en` is 0 stores no parity error, even if `par_en` is set before that frame is read.
- R2: With `par_en`=1 and `par_odd`=0 (even parity), a frame has a parity error when the count of ones in its data bits plus its parity bit is odd. With `par_odd`=1 (odd parity), it has a parity error when that count is even.
- R3: The flags shown belong to the character at the head of the FIFO. They stay unchanged until that character is read, and the next character's flags then appear.
- R4: `rx_done` is 1 exactly when at least one unread character is stored. A cycle with `rd_en`=1 and `rx_done`=1 consumes the head character.
- R5: The FIFO holds DEPTH characters (2 by default) and returns them in arrival order.
- R6: A frame that completes while the FIFO is full and no read happens in that cycle is dropped. `rd_ovr` reads 1 with the newest stored character and reads 0 with the characters before it.
- R7: A read and a completing frame in the same cycle lose no entry and duplicate no entry. This holds when the FIFO is empty, partly filled or full. When the FIFO is full, the read frees a slot and the frame is stored without an overrun.
- R8: While `rx_en` is 0, the FIFO is emptied on the next clock edge and completing frames are discarded.
- R9: A read while the FIFO is empty changes nothing. `rd_data` keeps the last consumed character, and `rd_perr`, `rd_ovr` and `rd_ferr` read 0.
- R10: `rd_ferr` is 1 when the stored stop bit of the head character is 0. DATA_W must lie between 5 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the FIFO and blocks frames |
| par_en | input | 1 | Parity checking on |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | DATA_W | Received data bits |
| frm_par | input | 1 | Received parity bit |
| frm_stop | input | 1 | Sampled stop bit |
| rd_en | input | 1 | Read strobe; consumes the head character |
| rd_data | output | DATA_W | Head character, or the last consumed character when empty |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ovr | output | 1 | Overrun marked on the head character |
| rd_ferr | output | 1 | Stop bit of the head character was 0 |
| rx_done | output | 1 | At least one unread character stored |

## Verification
A read strobe and a frame completion can fall in the same clock cycle. This is the collision that can lose or duplicate an entry. The bench provokes it with an empty FIFO, with one entry and with both slots full. It also raises the two events in separate cycles around a full FIFO, to show the overrun path against the no-overrun path. Each case is judged by draining the FIFO and comparing the sequence of characters and flags that comes out with the sequence computed from the stimulus.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

   // Per-character status carried through the FIFO beside the data.
   typedef struct packed {
      logic ovr;   // a later frame was dropped after this one
      logic perr;  // parity mismatch, checked at arrival
      logic stop;  // sampled stop-bit value
   } rxb_flags_t;

   function automatic logic calc_perr(input logic ones_odd, input logic odd_mode);
      // Mismatch when the parity of data plus parity bit differs from the mode.
      return ones_odd != odd_mode;
   endfunction

endpackage

// File: rtl/rxb_parity.sv
module rxb_parity #(
   parameter int DATA_W      = 8,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              chk_en,
   input  logic              odd_mode,
   input  logic [DATA_W-1:0] data,
   input  logic              par_bit,
   output logic              perr
);
   import uart_rxb_pkg::*;

   generate
      if (PAR_SUPPORT) begin : g_checker
         logic ones_odd;
         assign ones_odd = (^data) ^ par_bit;
         assign perr     = chk_en & calc_perr(ones_odd, odd_mode);
      end else begin : g_no_checker
         logic unused_in;
         assign unused_in = chk_en ^ odd_mode ^ par_bit ^ (^data);
         assign perr      = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush,
   input  logic                           push,
   input  logic [DATA_W-1:0]              wr_data,
   input  uart_rxb_pkg::rxb_flags_t       wr_flags,
   input  logic                           pop,
   output logic [DATA_W-1:0]              head_data,
   output uart_rxb_pkg::rxb_flags_t       head_flags,
   output logic                           empty,
   output logic                           full,
   output logic                           popped
);
   import uart_rxb_pkg::*;

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   initial assert (DEPTH >= 2) else $fatal(1, "rxb_fifo: DEPTH must be at least 2");

   logic [DATA_W-1:0] mem_data [DEPTH];
   rxb_flags_t        mem_flg  [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr, newest_ptr;
   logic [CW-1:0]     count;
   logic              do_pop, do_push, do_mark;

   function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
      return (p == LAST_IDX) ? '0 : p + 1'b1;
   endfunction

   assign empty      = (count == '0);
   assign full       = (count == FULL_CNT);
   assign do_pop     = pop & ~empty & ~flush;
   assign do_push    = push & (~full | do_pop) & ~flush;
   assign do_mark    = push & full & ~do_pop & ~flush;
   assign newest_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
   assign popped     = do_pop;

   assign head_data  = mem_data[rd_ptr];
   assign head_flags = mem_flg[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_inc(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_data[g] <= '0;
               mem_flg[g]  <= '0;
            end else if (do_push && wr_ptr == PW'(g)) begin
               mem_data[g] <= wr_data;
               mem_flg[g]  <= wr_flags;
            end else if (do_mark && newest_ptr == PW'(g)) begin
               mem_flg[g].ovr <= 1'b1;
            end
         end
      end
   endgenerate

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   // R7
   push_pop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty && !flush) |=> (count == $past(count)));

   // R6
   drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 2,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              frm_valid,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_par,
   input  logic              frm_stop,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_perr,
   output logic              rd_ovr,
   output logic              rd_ferr,
   output logic              rx_done
);
   import uart_rxb_pkg::*;

   // R10
   initial assert (DATA_W >= 5 && DATA_W <= 8)
      else $fatal(1, "uart_rx_buf: DATA_W must be 5..8");

   logic              new_perr;
   rxb_flags_t        wr_flags, head_flags;
   logic [DATA_W-1:0] head_data, last_q;
   logic              fifo_empty, fifo_full, popped;

   rxb_parity #(.DATA_W(DATA_W), .PAR_SUPPORT(PAR_SUPPORT)) u_par (
      .chk_en  (par_en),
      .odd_mode(par_odd),
      .data    (frm_data),
      .par_bit (frm_par),
      .perr    (new_perr)
   );

   always_comb begin
      wr_flags      = '0;
      wr_flags.perr = new_perr;
      wr_flags.stop = frm_stop;
   end

   rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (~rx_en),
      .push      (frm_valid),
      .wr_data   (frm_data),
      .wr_flags  (wr_flags),
      .pop       (rd_en),
      .head_data (head_data),
      .head_flags(head_flags),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .popped    (popped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q <= '0;
      else if (popped) last_q <= head_data;
   end

   assign rx_done = ~fifo_empty;
   assign rd_data = fifo_empty ? last_q : head_data;
   assign rd_perr = ~fifo_empty & par_en & head_flags.perr;
   assign rd_ovr  = ~fifo_empty & head_flags.ovr;
   assign rd_ferr = ~fifo_empty & ~head_flags.stop;

   // R9
   empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rx_done && !(frm_valid && rx_en)) |=> $stable(rd_data));

   // R4
   done_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && rx_en && !rd_en) |=> rx_done);

   // R8
   disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_done);

   // R6
   full_stays_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && rx_en && !rd_en) |=> rx_done);

endmodule

// File: tb/uart_rx_buf_tb.sv
module uart_rx_buf_tb;
   localparam int W = 5;

   logic clk = 0, rst_n = 0;
   logic rx_en = 0, par_en = 0, par_odd = 0;
   logic frm_valid = 0, frm_par = 0, frm_stop = 0, rd_en = 0;
   logic [W-1:0] frm_data = '0;
   logic [W-1:0] rd_data;
   logic rd_perr, rd_ovr, rd_ferr, rx_done;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   uart_rx_buf #(.DATA_W(W), .DEPTH(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
      .frm_valid(frm_valid), .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop),
      .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ovr(rd_ovr),
      .rd_ferr(rd_ferr), .rx_done(rx_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [W-1:0] d, input logic p,
                       input logic s, input logic r);
      @(negedge clk);
      frm_valid = v; frm_data = d; frm_par = p; frm_stop = s; rd_en = r;
      @(posedge clk);
      #1;
      frm_valid = 0; rd_en = 0;
   endtask

   task automatic head(input string req, input int d, input int pe, input int ov, input int fe);
      chk({req, " done"}, rx_done, 1);
      chk({req, " data"}, rd_data, d);
      chk({req, " perr"}, rd_perr, pe);
      chk({req, " ovr"}, rd_ovr, ov);
      chk({req, " ferr"}, rd_ferr, fe);
   endtask

   task automatic empty_chk(input string req);
      chk({req, " done"}, rx_done, 0);
      chk({req, " perr"}, rd_perr, 0);
      chk({req, " ovr"}, rd_ovr, 0);
      chk({req, " ferr"}, rd_ferr, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      #25;
      empty_chk("R4 reset");
      chk("R9 reset data", rd_data, 0);
      rst_n = 1;
      rx_en = 1;

      // R1 R2 R10: sweep of every data value, parity bit and mode.
      for (int m = 0; m < 4; m++) begin
         par_en = m[1]; par_odd = m[0];
         for (int d = 0; d < 32; d++) begin
            for (int p = 0; p < 2; p++) begin
               logic [W-1:0] dv;
               int ones, pe, st;
               dv = W'(d);
               ones = $countones(dv) + p;
               pe = (m[1] && ((ones % 2) != m[0])) ? 1 : 0;
               st = d % 2;
               step(1, dv, p[0], st[0], 0);
               head(m[1] ? "R2 sweep" : "R1 sweep", d, pe, 0, 1 - st);
               step(0, '0, 0, 1, 1);
               chk("R4 drained", rx_done, 0);
               chk("R9 last data", rd_data, d);
            end
         end
      end

      // R3: flag tied to the arrival-time enable.
      par_en = 1; par_odd = 0;
      step(1, 5'h01, 0, 1, 0);          // bad even parity, checked
      par_en = 0;
      step(1, 5'h03, 1, 1, 0);          // bad but unchecked
      #1 chk("R1 gated output", rd_perr, 0);
      par_en = 1;
      #1 chk("R3 head perr kept", rd_perr, 1);
      step(0, '0, 0, 1, 1);
      head("R1 unchecked stays clear", 3, 0, 0, 0);
      step(0, '0, 0, 1, 1);

      // R5 R6: order and overrun marking.
      par_en = 0;
      step(1, 5'h0A, 0, 1, 0);
      step(1, 5'h0B, 0, 0, 0);
      step(1, 5'h0C, 0, 1, 0);          // dropped
      step(1, 5'h0D, 0, 1, 0);          // dropped
      head("R6 first no ovr", 10, 0, 0, 0);
      step(0, '0, 0, 1, 1);
      head("R5 R6 second ovr", 11, 0, 1, 1);
      step(0, '0, 0, 1, 1);
      empty_chk("R6 lost frames");

      // R7: collisions at empty, one entry and full.
      step(1, 5'h11, 0, 1, 1);
      head("R7 empty collide", 17, 0, 0, 0);
      step(1, 5'h12, 0, 1, 1);
      head("R7 single collide", 18, 0, 0, 0);
      step(1, 5'h13, 0, 1, 0);
      step(1, 5'h14, 0, 1, 1);          // full: read frees slot
      head("R7 full collide", 19, 0, 0, 0);
      step(0, '0, 0, 1, 1);
      head("R7 full collide next", 20, 0, 0, 0);
      step(0, '0, 0, 1, 1);
      empty_chk("R7 drained");

      // R9: read on empty.
      step(0, '0, 0, 1, 1);
      chk("R9 empty read data", rd_data, 20);
      empty_chk("R9 empty read");

      // R8: flush and discard while disabled.
      step(1, 5'h15, 0, 1, 0);
      step(1, 5'h16, 0, 1, 0);
      rx_en = 0;
      step(1, 5'h17, 0, 1, 0);
      empty_chk("R8 flushed");
      rx_en = 1;
      step(0, '0, 0, 1, 0);
      empty_chk("R8 stays empty");
      step(1, 5'h18, 0, 1, 0);
      head("R8 resumes", 24, 0, 0, 0);
      step(0, '0, 0, 1, 1);

      finish_run();
   end
endmodule